// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block lets synchronous logic read and write an external static RAM that has no clock. Each transfer is asked for with a single-cycle request that carries an address, write data and a direction flag. The controller registers these values when it accepts the request. It then drives the memory's address, its two chip-select pins (one active low, one active high), its write strobe and output enable (both active low), and a split data bus made of an output, an output enable and an input. Every phase is timed by counting clock cycles, so address setup, strobe width, data hold and read access time are met by construction. A one-cycle acknowledge marks the end of the transfer.

A parameter selects which pin ends a write. In the write-strobe style the chip is selected and the write strobe is pulsed. In the chip-select style the write strobe is lowered first and the chip select is pulsed. A second parameter decides whether the chip stays selected while idle after a read, or whether it is deselected between accesses. Parts that misread address changes while selected need the second choice.

Top module: `sram_async_ctrl`

## Requirements
- R1: A read drives the captured address with the chip selected (`sram_ce1_n_o`=0, `sram_ce2_o`=1), write strobe high and output enable high for `T_SETUP` cycles. It then holds output enable low for exactly `T_ACCESS` cycles and captures `sram_dq_i` into `rdata_o` on the clock edge that ends that window. `rdata_o` keeps this value until the next read completes.
- R2: `ack_o` is high for exactly one cycle. It rises `T_SETUP+T_ACCESS` clock edges after the edge that accepts a read, and `T_SETUP+T_PULSE+T_HOLD` edges after the edge that accepts a write (`req_wr_i`=1 means write).
- R3: With `CE_STROBE`=0, a write selects the chip first and keeps the address stable. It then holds the write strobe low for exactly `T_PULSE` cycles while driving `sram_dq_o`, and keeps the bus driven for `T_HOLD` cycles after the strobe rises. The bus is therefore driven for `T_PULSE+T_HOLD` cycles in total.
- R4: With `CE_STROBE`=1, the write strobe is already low while the chip is deselected. The chip is then selected for exactly `T_PULSE` cycles with the bus driven. Deselecting it ends the write, and the strobe returns high only after the hold interval.
- R5: Output enable is never low while the write strobe is low, and it stays high for the whole of every write.
- R6: `sram_dq_oe_o` is high only during the strobe and hold phases of a write, and never while output enable is low.
- R7: A request is accepted only when the controller is idle. A request raised during an access is ignored: it produces no acknowledge and no memory change, and the address pins do not move.
- R8: Address, write data and direction are registered on acceptance. Changes on the request inputs during an access do not reach the memory pins.
- R9: With `HOLD_CE`=1, the chip stays selected while idle after a read completes. With `HOLD_CE`=0, it is deselected whenever the controller is idle.
- R10: Reset deselects the chip, drives the write strobe and output enable high, releases the data bus and holds `ack_o` low.
- R11: The timing parameters are cycle counts of at least 1. Any access that reads a location returns the data most recently written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, sampled while idle |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Access address |
| req_wdata_i | input | DATA_W | Write data |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Last captured read data |
| sram_addr_o | output | ADDR_W | Memory address pins |
| sram_ce1_n_o | output | 1 | Chip select, active low |
| sram_ce2_o | output | 1 | Chip select, active high |
| sram_we_n_o | output | 1 | Write strobe, active low |
| sram_oe_n_o | output | 1 | Output enable, active low |
| sram_dq_o | output | DATA_W | Data bus value driven toward the memory |
| sram_dq_oe_o | output | 1 | Data bus output enable |
| sram_dq_i | input | DATA_W | Data bus value read from the memory |

## Verification
Two events can fall in the same cycle. First, the acknowledge of one access can coincide with the acceptance of the next: the driver raises the following request at the very edge where it sees the acknowledge. The scoreboard then checks the exact latency of each transfer and that no stray acknowledge appears. Second, a request can arrive while an access is in its setup phase. This is provoked by a write request to the same address with altered data; it must produce no acknowledge, and a later read must show that the location still holds the accepted data. Two instances, one per write style, run side by side against behavioural memory models. The models flag any break of the setup, strobe-priority and bus-contention rules.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    // Access sequencer phases
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_READ_WAIT
    } acc_state_e;

    // Memory control pin set, stored in positive sense where useful
    typedef struct packed {
        logic sel;    // chip selected (ce1 low, ce2 high)
        logic we_n;   // write strobe, active low
        logic oe_n;   // output enable, active low
        logic drive;  // controller drives the data bus
    } pin_ctl_t;

    localparam pin_ctl_t PIN_OFF = '{sel: 1'b0, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
    parameter int unsigned CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             done_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done_o = (cnt_q == '0);

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == $past(load_val_i)));

    // R2
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_req_capture.sv
module sram_req_capture #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              wr_d_o,
    output logic              wr_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o
);

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (accept_i) begin
            cap_d.wr    = wr_i;
            cap_d.addr  = addr_i;
            cap_d.wdata = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign wr_d_o  = cap_d.wr;
    assign wr_o    = cap_q.wr;
    assign addr_o  = cap_q.addr;
    assign wdata_o = cap_q.wdata;

    // R8
    hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_i |=> ($stable(addr_o) && $stable(wdata_o) && $stable(wr_o)));

endmodule

// File: rtl/sram_pin_ctl.sv
module sram_pin_ctl
    import sram_ctrl_pkg::*;
#(
    parameter bit CE_STROBE = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  acc_state_e state_d_i,
    input  logic       wr_d_i,
    input  logic       hold_sel_d_i,
    output logic       ce1_n_o,
    output logic       ce2_o,
    output logic       we_n_o,
    output logic       oe_n_o,
    output logic       dq_oe_o
);

    pin_ctl_t wr_setup, wr_strobe, wr_hold;
    pin_ctl_t ctl_d, ctl_q;

    generate
        if (CE_STROBE) begin : g_ce_style
            // strobe low first, chip select pulses the write
            assign wr_setup  = '{sel: 1'b0, we_n: 1'b0, oe_n: 1'b1, drive: 1'b0};
            assign wr_strobe = '{sel: 1'b1, we_n: 1'b0, oe_n: 1'b1, drive: 1'b1};
            assign wr_hold   = '{sel: 1'b0, we_n: 1'b0, oe_n: 1'b1, drive: 1'b1};
        end else begin : g_we_style
            // chip selected first, write strobe pulses the write
            assign wr_setup  = '{sel: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
            assign wr_strobe = '{sel: 1'b1, we_n: 1'b0, oe_n: 1'b1, drive: 1'b1};
            assign wr_hold   = '{sel: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b1};
        end
    endgenerate

    always_comb begin
        ctl_d = PIN_OFF;
        case (state_d_i)
            ST_IDLE:      ctl_d.sel = hold_sel_d_i;
            ST_SETUP:     ctl_d = wr_d_i ? wr_setup
                                         : '{sel: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
            ST_STROBE:    ctl_d = wr_strobe;
            ST_HOLD:      ctl_d = wr_hold;
            ST_READ_WAIT: ctl_d = '{sel: 1'b1, we_n: 1'b1, oe_n: 1'b0, drive: 1'b0};
            default:      ctl_d = PIN_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= PIN_OFF;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ce1_n_o = ~ctl_q.sel;
    assign ce2_o   = ctl_q.sel;
    assign we_n_o  = ctl_q.we_n;
    assign oe_n_o  = ctl_q.oe_n;
    assign dq_oe_o = ctl_q.drive;

    // R5
    strobe_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n_o |-> oe_n_o);

    // R6
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe_o |-> oe_n_o);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned T_SETUP   = 2,
    parameter int unsigned T_PULSE   = 3,
    parameter int unsigned T_HOLD    = 1,
    parameter int unsigned T_ACCESS  = 3,
    parameter bit          CE_STROBE = 1'b0,
    parameter bit          HOLD_CE   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              req_wr_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              ack_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [ADDR_W-1:0] sram_addr_o,
    output logic              sram_ce1_n_o,
    output logic              sram_ce2_o,
    output logic              sram_we_n_o,
    output logic              sram_oe_n_o,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe_o,
    input  logic [DATA_W-1:0] sram_dq_i
);

    localparam int unsigned T_MAX_A = (T_SETUP > T_PULSE) ? T_SETUP : T_PULSE;
    localparam int unsigned T_MAX_B = (T_HOLD > T_ACCESS) ? T_HOLD : T_ACCESS;
    localparam int unsigned T_MAX   = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
    localparam int unsigned CNT_W   = (T_MAX > 1) ? $clog2(T_MAX) : 1;

    localparam logic [CNT_W-1:0] LD_SETUP  = CNT_W'(T_SETUP - 1);
    localparam logic [CNT_W-1:0] LD_PULSE  = CNT_W'(T_PULSE - 1);
    localparam logic [CNT_W-1:0] LD_HOLD   = CNT_W'(T_HOLD - 1);
    localparam logic [CNT_W-1:0] LD_ACCESS = CNT_W'(T_ACCESS - 1);

    typedef struct packed {
        acc_state_e        st;
        logic              ack;
        logic              hold_sel;
        logic [DATA_W-1:0] rdata;
    } fsm_t;

    fsm_t             fsm_d, fsm_q;
    logic             accept;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             cap_wr_d, cap_wr_q;

    sram_cycle_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .done_o     (tmr_done)
    );

    sram_req_capture #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) capture_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .wr_i     (req_wr_i),
        .addr_i   (req_addr_i),
        .wdata_i  (req_wdata_i),
        .wr_d_o   (cap_wr_d),
        .wr_o     (cap_wr_q),
        .addr_o   (sram_addr_o),
        .wdata_o  (sram_dq_o)
    );

    sram_pin_ctl #(
        .CE_STROBE (CE_STROBE)
    ) pins_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .state_d_i    (fsm_d.st),
        .wr_d_i       (cap_wr_d),
        .hold_sel_d_i (fsm_d.hold_sel),
        .ce1_n_o      (sram_ce1_n_o),
        .ce2_o        (sram_ce2_o),
        .we_n_o       (sram_we_n_o),
        .oe_n_o       (sram_oe_n_o),
        .dq_oe_o      (sram_dq_oe_o)
    );

    always_comb begin
        fsm_d     = fsm_q;
        fsm_d.ack = 1'b0;
        accept    = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        case (fsm_q.st)
            ST_IDLE: begin
                if (req_i) begin
                    accept         = 1'b1;
                    fsm_d.st       = ST_SETUP;
                    fsm_d.hold_sel = 1'b0;
                    tmr_load       = 1'b1;
                    tmr_val        = LD_SETUP;
                end
            end
            ST_SETUP: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    if (cap_wr_q) begin
                        fsm_d.st = ST_STROBE;
                        tmr_val  = LD_PULSE;
                    end else begin
                        fsm_d.st = ST_READ_WAIT;
                        tmr_val  = LD_ACCESS;
                    end
                end
            end
            ST_STROBE: begin
                if (tmr_done) begin
                    fsm_d.st = ST_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = LD_HOLD;
                end
            end
            ST_HOLD: begin
                if (tmr_done) begin
                    fsm_d.st  = ST_IDLE;
                    fsm_d.ack = 1'b1;
                end
            end
            ST_READ_WAIT: begin
                if (tmr_done) begin
                    fsm_d.st       = ST_IDLE;
                    fsm_d.ack      = 1'b1;
                    fsm_d.rdata    = sram_dq_i;
                    fsm_d.hold_sel = HOLD_CE;
                end
            end
            default: begin
                fsm_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{st: ST_IDLE, ack: 1'b0, hold_sel: 1'b0, rdata: '0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign ack_o   = fsm_q.ack;
    assign rdata_o = fsm_q.rdata;

    // R2
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    // R7
    busy_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st != ST_IDLE) |=> $stable(sram_addr_o));

    // R1
    read_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_READ_WAIT) |-> (!sram_oe_n_o && !sram_ce1_n_o && sram_ce2_o));

    // R6
    bus_only_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe_o |-> (fsm_q.st == ST_STROBE || fsm_q.st == ST_HOLD));

    generate
        if (CE_STROBE) begin : g_chk_ce
            // R4
            ce_write_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($fell(sram_ce1_n_o) && !sram_we_n_o) |-> !$past(sram_we_n_o));
        end else begin : g_chk_we
            // R3
            we_write_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(sram_we_n_o) |-> ($past(!sram_ce1_n_o) && $stable(sram_addr_o)));
        end
        if (!HOLD_CE) begin : g_chk_nohold
            // R9
            idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (fsm_q.st == ST_IDLE) |-> (sram_ce1_n_o && !sram_ce2_o));
        end
    endgenerate

endmodule

// File: tb/sram_async_ctrl_tb_top.sv
module sram_beh_model #(
    parameter int unsigned AW       = 10,
    parameter int unsigned DW       = 16,
    parameter bit          CE_STYLE = 1'b0
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    input  logic          ce1_n,
    input  logic          ce2,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [DW-1:0] dq_out,
    input  logic          dq_oe,
    output logic [DW-1:0] dq_in,
    output int            violations
);
    logic [DW-1:0] mem [2**AW];
    logic          sel, drive, wr_now;
    logic          p_wr, p_sel, p_we_n, p_dq_oe;
    logic [AW-1:0] p_addr;
    logic [DW-1:0] p_dq;

    assign sel    = !ce1_n && ce2;
    assign drive  = sel && we_n && !oe_n;
    assign wr_now = sel && !we_n;
    assign dq_in  = drive ? mem[addr] : 'z;

    initial begin
        for (int i = 0; i < 2**AW; i++) mem[i] = '0;
        violations = 0;
        p_wr = 1'b0; p_sel = 1'b0; p_we_n = 1'b1; p_dq_oe = 1'b0;
        p_addr = '0; p_dq = '0;
    end

    always @(negedge clk) begin
        if (wr_now && !oe_n) begin
            violations++; $display("model: output enable low during write");
        end
        if (dq_oe && drive) begin
            violations++; $display("model: bus contention");
        end
        if (!p_wr && wr_now) begin
            if (CE_STYLE) begin
                if (p_we_n || p_sel) begin
                    violations++; $display("model: strobe not low before select");
                end
            end else if (!p_sel || !p_we_n || addr != p_addr) begin
                violations++; $display("model: no setup before strobe");
            end
        end
        if (p_wr && wr_now && addr != p_addr) begin
            violations++; $display("model: address moved during write");
        end
        if (p_wr && !wr_now) begin
            if (!p_dq_oe || !dq_oe) begin
                violations++; $display("model: data not held around write end");
            end
            mem[p_addr] = p_dq;
        end
        p_wr = wr_now; p_sel = sel; p_we_n = we_n; p_dq_oe = dq_oe;
        p_addr = addr; p_dq = dq_out;
    end
endmodule

module sram_async_ctrl_tb_top;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned AW = 10;
    localparam int unsigned DW = 16;
    localparam int unsigned TS = 2, TP = 3, TH = 1, TA = 3;
    localparam int unsigned LAT_WR = 1 + TS + TP + TH;
    localparam int unsigned LAT_RD = 1 + TS + TA;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, req_wr = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;

    logic ack_a, ack_b;
    logic [DW-1:0] rdata_a, rdata_b, dqo_a, dqo_b, dqi_a, dqi_b;
    logic [AW-1:0] addr_a, addr_b;
    logic ce1n_a, ce2_a, wen_a, oen_a, dqoe_a;
    logic ce1n_b, ce2_b, wen_b, oen_b, dqoe_b;
    int   viol_a, viol_b;

    int checks = 0, failures = 0;
    logic [31:0] cyc = '0;
    bit   finished = 1'b0;

    typedef struct packed {
        logic          wr;
        logic [DW-1:0] data;
        logic [31:0]   issue;
    } exp_t;
    exp_t sbq[$];
    logic [DW-1:0] shadow [2**AW];

    int oe_run_a = 0, oe_last_a = 0, we_run_a = 0, we_last_a = 0;
    int drv_run_a = 0, drv_last_a = 0, cw_run_b = 0, cw_last_b = 0;
    logic ack_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sram_async_ctrl #(.ADDR_W(AW), .DATA_W(DW), .T_SETUP(TS), .T_PULSE(TP),
        .T_HOLD(TH), .T_ACCESS(TA), .CE_STROBE(1'b0), .HOLD_CE(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .req_wr_i(req_wr),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata), .ack_o(ack_a), .rdata_o(rdata_a),
        .sram_addr_o(addr_a), .sram_ce1_n_o(ce1n_a), .sram_ce2_o(ce2_a),
        .sram_we_n_o(wen_a), .sram_oe_n_o(oen_a), .sram_dq_o(dqo_a),
        .sram_dq_oe_o(dqoe_a), .sram_dq_i(dqi_a));

    sram_async_ctrl #(.ADDR_W(AW), .DATA_W(DW), .T_SETUP(TS), .T_PULSE(TP),
        .T_HOLD(TH), .T_ACCESS(TA), .CE_STROBE(1'b1), .HOLD_CE(1'b1)) dut_ce_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .req_wr_i(req_wr),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata), .ack_o(ack_b), .rdata_o(rdata_b),
        .sram_addr_o(addr_b), .sram_ce1_n_o(ce1n_b), .sram_ce2_o(ce2_b),
        .sram_we_n_o(wen_b), .sram_oe_n_o(oen_b), .sram_dq_o(dqo_b),
        .sram_dq_oe_o(dqoe_b), .sram_dq_i(dqi_b));

    sram_beh_model #(.AW(AW), .DW(DW), .CE_STYLE(1'b0)) mdl_we_i (
        .clk(clk), .addr(addr_a), .ce1_n(ce1n_a), .ce2(ce2_a), .we_n(wen_a),
        .oe_n(oen_a), .dq_out(dqo_a), .dq_oe(dqoe_a), .dq_in(dqi_a), .violations(viol_a));

    sram_beh_model #(.AW(AW), .DW(DW), .CE_STYLE(1'b1)) mdl_ce_i (
        .clk(clk), .addr(addr_b), .ce1_n(ce1n_b), .ce2(ce2_b), .we_n(wen_b),
        .oe_n(oen_b), .dq_out(dqo_b), .dq_oe(dqoe_b), .dq_in(dqi_b), .violations(viol_b));

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Monitor: pin run lengths and scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (!oen_a) oe_run_a++; else if (oe_run_a != 0) begin oe_last_a = oe_run_a; oe_run_a = 0; end
            if (!wen_a) we_run_a++; else if (we_run_a != 0) begin we_last_a = we_run_a; we_run_a = 0; end
            if (dqoe_a) drv_run_a++; else if (drv_run_a != 0) begin drv_last_a = drv_run_a; drv_run_a = 0; end
            if (!ce1n_b && ce2_b && !wen_b) cw_run_b++;
            else if (cw_run_b != 0) begin cw_last_b = cw_run_b; cw_run_b = 0; end

            if (ack_a || ack_b) begin
                chk(ack_a == ack_b, "R2", "ack of both styles aligned", 32'(ack_b), 32'(ack_a));
                // R2 single-cycle pulse
                chk(!ack_prev, "R2", "ack wider than one cycle", 32'(ack_prev), 32'd0);
            end
            if (ack_a) begin
                if (sbq.size() == 0) begin
                    chk(1'b0, "R7", "ack without accepted request", 32'd1, 32'd0);
                end else begin
                    exp_t it;
                    it = sbq.pop_front();
                    if (it.wr) begin
                        chk(cyc - it.issue == LAT_WR, "R2", "write latency", cyc - it.issue, LAT_WR);
                        chk(we_last_a == TP, "R3", "strobe low cycles", 32'(we_last_a), TP);
                        chk(drv_last_a == TP + TH, "R3", "bus drive cycles", 32'(drv_last_a), TP + TH);
                        chk(cw_last_b == TP, "R4", "select pulse cycles", 32'(cw_last_b), TP);
                    end else begin
                        chk(cyc - it.issue == LAT_RD, "R2", "read latency", cyc - it.issue, LAT_RD);
                        chk(oe_last_a == TA, "R1", "output enable cycles", 32'(oe_last_a), TA);
                        chk(rdata_a == it.data, "R11", "read data", 32'(rdata_a), 32'(it.data));
                        chk(rdata_b == it.data, "R11", "read data ce style", 32'(rdata_b), 32'(it.data));
                    end
                end
            end
            ack_prev = ack_a;
        end
    end

    // Driver: issues one access and pushes the expectation
    task automatic do_access(input bit wr, input logic [AW-1:0] a,
                             input logic [DW-1:0] d, input bit poke);
        exp_t it;
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
        it.wr = wr; it.data = wr ? '0 : shadow[a]; it.issue = cyc;
        sbq.push_back(it);
        if (wr) shadow[a] = d;
        @(negedge clk);
        // R8: scramble inputs after acceptance
        req = 1'b0; req_wr = ~wr; req_addr = ~a; req_wdata = ~d;
        if (poke) begin
            // R7: request during setup phase must be ignored
            @(negedge clk);
            req = 1'b1; req_wr = 1'b1; req_addr = a; req_wdata = d ^ 16'h5A3C;
            @(negedge clk);
            req = 1'b0;
        end
        while (!ack_a) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 2**AW; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(ce1n_a && !ce2_a && ce1n_b && !ce2_b, "R10", "chip deselected", {ce1n_a, ce2_a, ce1n_b, ce2_b}, 4'b1010);
        chk(wen_a && oen_a && wen_b && oen_b, "R10", "strobes high", {wen_a, oen_a, wen_b, oen_b}, 4'hF);
        chk(!dqoe_a && !dqoe_b && !ack_a && !ack_b, "R10", "bus released, no ack", {dqoe_a, dqoe_b, ack_a, ack_b}, 4'h0);

        do_access(1'b1, 10'd0,    16'h1234, 1'b0);
        do_access(1'b1, 10'h3FF,  16'hFFFF, 1'b0);
        do_access(1'b1, 10'd5,    16'hA5A5, 1'b0);
        for (int i = 0; i < 8; i++) do_access(1'b1, AW'(16 + i), DW'(1 << (2 * i)), (i == 3));
        do_access(1'b0, 10'd0, '0, 1'b0);
        @(negedge clk);
        // R9: idle after read, chip held in one instance only
        chk(ce1n_a == 1'b1, "R9", "deselect when not holding", 32'(ce1n_a), 32'd1);
        chk(ce1n_b == 1'b0 && ce2_b, "R9", "select held after read", 32'(ce1n_b), 32'd0);
        do_access(1'b0, 10'h3FF, '0, 1'b0);
        do_access(1'b0, 10'd5,   '0, 1'b1);
        for (int i = 0; i < 8; i++) do_access(1'b0, AW'(16 + i), '0, 1'b0);
        do_access(1'b0, 10'd100, '0, 1'b0);
        do_access(1'b1, 10'd5, 16'h0000, 1'b1);
        do_access(1'b0, 10'd5, '0, 1'b0);
        do_access(1'b0, 10'd5, '0, 1'b0);
        do_access(1'b1, 10'd7, 16'h0F0F, 1'b0);
        @(negedge clk);
        // R9: a write clears the held select
        chk(ce1n_b == 1'b1, "R9", "select released after write", 32'(ce1n_b), 32'd1);
        repeat (4) @(negedge clk);
        chk(sbq.size() == 0, "R7", "outstanding expectations", 32'(sbq.size()), 32'd0);
        chk(viol_a == 0, "R3", "strobe-style timing rule breaks (R5 R6)", 32'(viol_a), 32'd0);
        chk(viol_b == 0, "R4", "select-style timing rule breaks (R5 R6)", 32'(viol_b), 32'd0);
        finish_run();
    end

endmodule